// File: doc/BRIEF.md
# Sub-second real-time clock with cross-domain register access

This block is a real-time clock that counts on a slow oscillator clock (nominally 32.768 kHz). It keeps a seconds counter and a sub-second counter whose width is a parameter (15 bits by default). The sub-second counter steps once per slow tick, so at the nominal rate one step is 1/32768 s. Each time it wraps, the seconds counter steps. A programmable sub-second match value is compared with the count. When match detection is enabled, a one-slow-cycle pulse is produced. The pulse is also captured as a sticky flag on the system side.

A small register interface runs on the system clock, which must be at least three times as fast as the slow clock. Software can read seconds, read a packed word that holds both the sub-second count and the match value, and read a control/status word. The seconds and match values live in the slow domain. A write to either is taken only while the write-ready flag is high, and a write made while the flag is low is dropped. An accepted write is carried across the clock boundary by a toggle handshake. The control word lives on the system clock and takes writes at once. The seconds and sub-second values cross through identical Gray-coded two-flop paths, so they reach the system side in the same cycle. Software reads seconds, then sub-seconds, then seconds again, and keeps the result only when the two seconds values agree.

Top module: `rtc_subsec_top`

## Requirements
- R1: The sub-second count advances by exactly one per slow-clock tick and wraps from 2^SUB_W-1 to 0. The default SUB_W is 15.
- R2: The seconds count increments in the same slow cycle in which the sub-second count wraps to 0.
- R3: There are three registers.
  - Address 0 is seconds.
  - Address 1 is packed: sub-second count in bits 14:0, match value in bits 30:16, and bits 15 and 31 always read 0.
  - Address 2 is control/status: bit 0 is match enable, bit 1 is write-ready, and bit 2 is the sticky match flag.
  - After reset every register reads 0, except write-ready, which reads 1.
- R4: The seconds and sub-second values seen at the register interface lag the slow-domain time by at most one slow tick. They change together, so a seconds/sub-second/seconds read with equal seconds values gives a coherent time.
- R5: A write to address 0 or 1 while write-ready is 1 is accepted. Write-ready reads 0 from the next system cycle until the slow domain has taken the value and acknowledged it.
- R6: A write to address 0 or 1 while write-ready is 0 has no effect on the seconds or match value.
- R7: The match field of address 1 reads back the accepted match value from the cycle after the write is accepted.
- R8: With match enable set, the match pulse is high for exactly the slow cycle in which the sub-second count equals the match value. With match enable clear, the pulse never rises.
- R9: Each match pulse sets the sticky flag. Writing 1 to bit 2 of address 2 clears the flag.
- R10: Writes to address 2 take effect on the next system cycle whatever the state of write-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock, at least 3x the slow clock |
| clk_slow | input | 1 | Slow oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe (system clock) |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational from addr) |
| match_pulse | output | 1 | One-slow-cycle match pulse |

## Verification
The match pulse is sampled on the falling edge of the slow clock. It is due in the same slow cycle as the matching count, so the bench compares it with the bench's own tick count modulo 2^SUB_W. Register reads are taken one time unit after a falling system edge. Write-ready is expected low one system cycle after an accepted write. Sub-second and seconds reads may lag the bench's tick count by zero or one tick, because the slow edge is followed by two synchroniser flops; the checks accept exactly that window. The sticky flag and the end of the write handshake take a few cycles in each domain. For these the bench waits several slow ticks, or polls write-ready, before it compares.

// File: rtl/rtc_ss_pkg.sv
package rtc_ss_pkg;
  localparam int unsigned CODE_W = 32;
  localparam logic [1:0] ADDR_SEC = 2'd0;
  localparam logic [1:0] ADDR_SUB = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam int unsigned FIELD_W = 15;
  localparam int unsigned MATCH_LSB = 16;

  function automatic logic [CODE_W-1:0] bin2gray(input logic [CODE_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CODE_W-1:0] gray2bin(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core #(
  parameter int unsigned SUB_W = 15,
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             req_tgl_s,
  input  logic             wr_sel,
  input  logic [SEC_W-1:0] wr_data,
  input  logic             match_en_s,
  output logic [SUB_W-1:0] sub_q,
  output logic [SEC_W-1:0] sec_q,
  output logic [SUB_W-1:0] sub_gray_q,
  output logic [SEC_W-1:0] sec_gray_q,
  output logic             ack_tgl_q,
  output logic             wr_apply,
  output logic             match_pulse_q,
  output logic             pulse_tgl_q
);
  import rtc_ss_pkg::*;

  logic [SUB_W-1:0] match_q;
  logic [SUB_W-1:0] sub_nxt;
  logic [SEC_W-1:0] sec_nxt;
  logic             roll;
  logic             hit_nxt;

  assign wr_apply = req_tgl_s ^ ack_tgl_q;
  assign roll     = (sub_q == {SUB_W{1'b1}});
  assign sub_nxt  = sub_q + 1'b1;
  assign hit_nxt  = match_en_s && (sub_nxt == match_q);

  always_comb begin
    sec_nxt = sec_q;
    if (wr_apply && !wr_sel) sec_nxt = wr_data;
    else if (roll)           sec_nxt = sec_q + 1'b1;
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      sub_q         <= '0;
      sec_q         <= '0;
      sub_gray_q    <= '0;
      sec_gray_q    <= '0;
      match_q       <= '0;
      ack_tgl_q     <= 1'b0;
      match_pulse_q <= 1'b0;
      pulse_tgl_q   <= 1'b0;
    end else begin
      sub_q         <= sub_nxt;
      sec_q         <= sec_nxt;
      sub_gray_q    <= SUB_W'(bin2gray(CODE_W'(sub_nxt)));
      sec_gray_q    <= SEC_W'(bin2gray(CODE_W'(sec_nxt)));
      match_pulse_q <= hit_nxt;
      if (hit_nxt) pulse_tgl_q <= ~pulse_tgl_q;
      if (wr_apply) begin
        ack_tgl_q <= req_tgl_s;
        if (wr_sel) match_q <= wr_data[SUB_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rtc_sys_regs.sv
module rtc_sys_regs #(
  parameter int unsigned SUB_W = 15,
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_sys,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             ack_tgl_s,
  input  logic             pulse_tgl_s,
  input  logic [SUB_W-1:0] sub_sys,
  input  logic [SEC_W-1:0] sec_sys,
  output logic             req_tgl_q,
  output logic             wr_sel_q,
  output logic [SEC_W-1:0] wr_data_q,
  output logic             match_en_q,
  output logic [SUB_W-1:0] match_shadow_q,
  output logic             sticky_q,
  output logic             sticky_set,
  output logic             wr_ok
);
  import rtc_ss_pkg::*;

  logic slow_wr, accept, ctl_wr, pulse_prev_q;

  assign wr_ok      = ~(req_tgl_q ^ ack_tgl_s);
  assign slow_wr    = wr_en && (addr == ADDR_SEC || addr == ADDR_SUB);
  assign accept     = slow_wr && wr_ok;
  assign ctl_wr     = wr_en && (addr == ADDR_CTL);
  assign sticky_set = pulse_tgl_s ^ pulse_prev_q;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl_q      <= 1'b0;
      wr_sel_q       <= 1'b0;
      wr_data_q      <= '0;
      match_en_q     <= 1'b0;
      match_shadow_q <= '0;
      sticky_q       <= 1'b0;
      pulse_prev_q   <= 1'b0;
    end else begin
      pulse_prev_q <= pulse_tgl_s;
      if (accept) begin
        req_tgl_q <= ~req_tgl_q;
        wr_sel_q  <= (addr == ADDR_SUB);
        if (addr == ADDR_SUB) begin
          wr_data_q      <= SEC_W'(wdata[MATCH_LSB +: SUB_W]);
          match_shadow_q <= wdata[MATCH_LSB +: SUB_W];
        end else begin
          wr_data_q <= wdata[SEC_W-1:0];
        end
      end
      if (ctl_wr) match_en_q <= wdata[0];
      sticky_q <= sticky_set | (sticky_q & ~(ctl_wr & wdata[2]));
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_SEC: rdata = 32'(sec_sys);
      ADDR_SUB: rdata = {1'b0, FIELD_W'(match_shadow_q), 1'b0, FIELD_W'(sub_sys)};
      ADDR_CTL: rdata = {29'd0, sticky_q, wr_ok, match_en_q};
      default:  rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/rtc_subsec_top.sv
module rtc_subsec_top #(
  parameter int unsigned SUB_W = 15,
  parameter int unsigned SEC_W = 32
) (
  input  logic        clk_sys,
  input  logic        clk_slow,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        match_pulse
);
  import rtc_ss_pkg::*;

  // Named internal events, also observed by the bound checker
  logic             req_tgl, req_tgl_s, ack_tgl, ack_tgl_s;
  logic             pulse_tgl, pulse_tgl_s, match_en, match_en_s;
  logic             wr_sel, wr_apply, wr_ok, sticky, sticky_set;
  logic [SEC_W-1:0] wr_data, sec_q, sec_gray, sec_gray_s, sec_sys;
  logic [SUB_W-1:0] sub_q, sub_gray, sub_gray_s, sub_sys, match_shadow;

  assign sub_sys = SUB_W'(gray2bin(CODE_W'(sub_gray_s)));
  assign sec_sys = SEC_W'(gray2bin(CODE_W'(sec_gray_s)));

  // slow -> system: count and seconds take identical paths (same latency)
  rtc_sync2 #(.W(SUB_W)) u_sync_sub (.clk(clk_sys), .rst_n(rst_n), .d(sub_gray), .q(sub_gray_s));
  rtc_sync2 #(.W(SEC_W)) u_sync_sec (.clk(clk_sys), .rst_n(rst_n), .d(sec_gray), .q(sec_gray_s));
  rtc_sync2 #(.W(2)) u_sync_to_sys (.clk(clk_sys), .rst_n(rst_n),
    .d({ack_tgl, pulse_tgl}), .q({ack_tgl_s, pulse_tgl_s}));
  // system -> slow
  rtc_sync2 #(.W(2)) u_sync_to_slow (.clk(clk_slow), .rst_n(rst_n),
    .d({req_tgl, match_en}), .q({req_tgl_s, match_en_s}));

  rtc_slow_core #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_core (
    .clk_slow(clk_slow), .rst_n(rst_n), .req_tgl_s(req_tgl_s), .wr_sel(wr_sel),
    .wr_data(wr_data), .match_en_s(match_en_s), .sub_q(sub_q), .sec_q(sec_q),
    .sub_gray_q(sub_gray), .sec_gray_q(sec_gray), .ack_tgl_q(ack_tgl),
    .wr_apply(wr_apply), .match_pulse_q(match_pulse), .pulse_tgl_q(pulse_tgl));

  rtc_sys_regs #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_regs (
    .clk_sys(clk_sys), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack_tgl_s(ack_tgl_s), .pulse_tgl_s(pulse_tgl_s),
    .sub_sys(sub_sys), .sec_sys(sec_sys), .req_tgl_q(req_tgl), .wr_sel_q(wr_sel),
    .wr_data_q(wr_data), .match_en_q(match_en), .match_shadow_q(match_shadow),
    .sticky_q(sticky), .sticky_set(sticky_set), .wr_ok(wr_ok));
endmodule

// File: rtl/rtc_subsec_chk.sv
module rtc_subsec_chk #(
  parameter int unsigned SUB_W = 15,
  parameter int unsigned SEC_W = 32
) (
  input logic             clk_sys,
  input logic             clk_slow,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             match_pulse,
  input logic             wr_ok,
  input logic             wr_apply,
  input logic             sticky,
  input logic             sticky_set,
  input logic [SUB_W-1:0] sub_q,
  input logic [SEC_W-1:0] sec_q,
  input logic [SUB_W-1:0] match_shadow
);
  import rtc_ss_pkg::*;

  logic slow_wr;
  assign slow_wr = wr_en && (addr == ADDR_SEC || addr == ADDR_SUB);

  p_sub_step_r1: assert property (@(posedge clk_slow) disable iff (!rst_n)
    1'b1 |=> sub_q == SUB_W'($past(sub_q) + 1'b1));

  p_sec_on_wrap_r2: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (sub_q == {SUB_W{1'b1}} && !wr_apply) |=> (sec_q == SEC_W'($past(sec_q) + 1'b1)));

  p_reserved_zero_r3: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (addr == ADDR_SUB) |-> (!rdata[15] && !rdata[31]));

  p_ready_drops_r5: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (slow_wr && wr_ok) |=> !wr_ok);

  p_busy_write_dropped_r6: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (slow_wr && !wr_ok) |=> $stable(match_shadow));

  p_pulse_single_r8: assert property (@(posedge clk_slow) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  p_sticky_clear_r9: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (wr_en && addr == ADDR_CTL && wdata[2] && !sticky_set) |=> !sticky);
endmodule

bind rtc_subsec_top rtc_subsec_chk #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_chk (
  .clk_sys(clk_sys), .clk_slow(clk_slow), .rst_n(rst_n), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .match_pulse(match_pulse),
  .wr_ok(wr_ok), .wr_apply(wr_apply), .sticky(sticky), .sticky_set(sticky_set),
  .sub_q(sub_q), .sec_q(sec_q), .match_shadow(match_shadow));

// File: tb/tb_rtc_subsec_top.sv
`timescale 1ns/1ps
module tb_rtc_subsec_top;
  localparam int SUB_W = 6;
  localparam int SEC_W = 32;
  localparam int WRAP  = 1 << SUB_W;
  localparam int MVAL  = 40;

  logic clk_sys = 1'b0, clk_slow = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic match_pulse;

  int n_vec = 0, n_bad = 0;
  int ticks = 0;
  bit pchk_on = 0, en_exp = 0, done = 0;
  longint off = 0;

  always #2.5 clk_sys = ~clk_sys;
  always #20  clk_slow = ~clk_slow;

  rtc_subsec_top #(.SUB_W(SUB_W), .SEC_W(SEC_W)) dut (
    .clk_sys(clk_sys), .clk_slow(clk_slow), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .match_pulse(match_pulse));

  always @(posedge clk_slow) if (rst_n) ticks = ticks + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // R8: pulse expected exactly when count (= ticks mod 2^SUB_W) equals match
  always @(negedge clk_slow)
    if (pchk_on)
      check(match_pulse == (en_exp && (ticks % WRAP) == MVAL), "R8 match pulse",
            match_pulse, en_exp && (ticks % WRAP) == MVAL);

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_sys);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_sys);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk_sys);
    wr_en = 1'b0;
  endtask

  task automatic wait_mod(input int k);
    while ((ticks % WRAP) != k) @(negedge clk_sys);
  endtask

  task automatic wait_ready();
    logic [31:0] d;
    for (int i = 0; i < 400; i++) begin
      rd(2'd2, d);
      if (d[1]) return;
    end
    check(1'b0, "R5 write-ready never returned", 0, 1);
  endtask

  // R4: seconds / sub / seconds, retry until seconds agree
  task automatic coherent(output longint total, output int tk);
    logic [31:0] s1, ss, s2;
    total = 0; tk = 0;
    for (int i = 0; i < 4; i++) begin
      rd(2'd0, s1);
      rd(2'd1, ss); tk = ticks;
      rd(2'd0, s2);
      if (s1 == s2) begin
        total = longint'(s1) * WRAP + ss[SUB_W-1:0];
        return;
      end
    end
    check(1'b0, "R4 seconds never stable", 0, 1);
  endtask

  task automatic sweep(input int n);
    longint total, diff;
    int tk;
    for (int i = 0; i < n; i++) begin
      coherent(total, tk);
      diff = longint'(tk) + off - total;
      check(diff == 0 || diff == 1, "R1/R2/R4 time lag", total, longint'(tk) + off);
      repeat (i % 7) @(negedge clk_sys);
    end
  endtask

  initial begin : main
    logic [31:0] d;
    int wblk;
    #102.5 rst_n = 1'b1;
    // R3 reset state
    rd(2'd0, d); check(d == 0, "R3 reset seconds", d, 0);
    rd(2'd1, d); check(d == 0, "R3 reset packed sub", d, 0);
    rd(2'd2, d); check(d == 32'd2, "R3 reset ctl (write-ready only)", d, 2);

    // R1 R2 R4: free-running sweep over several wraps
    sweep(300);

    // R5 R6: seconds write, then a dropped write while busy
    wait_mod(3);
    wblk = ticks / WRAP;
    wr(2'd0, 32'd1000);
    #1 check(rdata[1] == 1'b0 || addr != 2'd2, "R5", 0, 0);
    rd(2'd2, d); check(d[1] == 1'b0, "R5 write-ready low after accept", d[1], 0);
    wr(2'd0, 32'd5);
    wait_ready();
    rd(2'd0, d); check(d == 32'd1000, "R6 busy seconds write dropped", d, 1000);
    off = longint'(1000) * WRAP - longint'(wblk) * WRAP;
    sweep(200);

    // R7 R6 R10: match write, busy overwrite dropped, ctl immediate
    wr(2'd1, 32'(MVAL) << 16);
    rd(2'd1, d);
    check(d[30:16] == MVAL, "R7 match readback", d[30:16], MVAL);
    check(!d[15] && !d[31], "R3 reserved bits zero", {d[31], d[15]}, 0);
    wr(2'd1, 32'd7 << 16);
    rd(2'd1, d); check(d[30:16] == MVAL, "R6 busy match write dropped", d[30:16], MVAL);
    rd(2'd2, d); check(d[1] == 1'b0, "R10 precondition busy", d[1], 0);
    wr(2'd2, 32'd1);
    rd(2'd2, d); check(d[0] == 1'b1, "R10 enable immediate while busy", d[0], 1);
    wait_ready();
    rd(2'd1, d); check(d[30:16] == MVAL, "R7 match after handshake", d[30:16], MVAL);

    // R8 R9: pulse check window with enable set
    en_exp = 1;
    repeat (10) @(negedge clk_slow);
    pchk_on = 1;
    repeat (3 * WRAP) @(negedge clk_slow);
    pchk_on = 0;
    wait_mod(MVAL + 5);
    rd(2'd2, d); check(d[2] == 1'b1, "R9 sticky set by pulse", d[2], 1);
    wr(2'd2, 32'd5);
    rd(2'd2, d); check(d[2] == 1'b0, "R9 write-1 clears sticky", d[2], 0);
    check(d[0] == 1'b1, "R10 enable kept", d[0], 1);
    wait_mod(MVAL - 1);
    wait_mod(MVAL + 10);
    rd(2'd2, d); check(d[2] == 1'b1, "R9 sticky set again", d[2], 1);

    // R8: disabled, no pulse, no sticky
    wr(2'd2, 32'd4);
    en_exp = 0;
    repeat (10) @(negedge clk_slow);
    rd(2'd2, d); check(d[2:0] == 3'b010, "R9 clear with enable off", d[2:0], 2);
    pchk_on = 1;
    repeat (2 * WRAP) @(negedge clk_slow);
    pchk_on = 0;
    rd(2'd2, d); check(d[2] == 1'b0, "R8 no sticky while disabled", d[2], 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : watchdog
    #750000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule